// File: doc/BRIEF.md
# Dual-Mode Frequency Meter

The block measures how fast an asynchronous digital signal toggles, using the local reference clock as its only timebase. A start strobe begins one measurement and also clears whatever the previous one left behind. The mode input picks one of two methods. The choice is sampled only at the start strobe.

In window mode, a window timer that runs separately from the edge counter opens a gate of a programmed number of reference cycles. The edge counter counts rising edges of the signal only while the gate is open. When the window closes, the block reports the count. Software later turns the count into hertz by dividing by the window length. In interval mode, one rising edge arms the measurement and the next rising edge latches the number of reference cycles between the two. This mode suits slow signals, where a window count would be too coarse. If the signal stays quiet for too long, the measurement ends with an overflow and a zero result.

The edge counter has a narrow low part and a rollover extension, so long windows keep their full count.

Top module: `freq_meter`

## Requirements
- R1: After reset, `result` is 0, `result_valid` is 0 and `overflow` is 0.
- R2: `sig_in` passes through two synchronizer flops before edge detection. Only low-to-high transitions are counted, and a high pulse that lasts one reference cycle counts once.
- R3: With `mode_recip`=0 at the start strobe, the window is G = `gate_len` reference cycles, and a `gate_len` of 0 acts as 1. `result` equals the number of rising edges detected in the G cycles that follow the start cycle. `result_valid` pulses G cycles after the start cycle.
- R4: The edge count is a low counter of CNT_LO_W bits with a CNT_HI_W-bit extension. The extension advances each time the low counter rolls over, so `result` = extension·2^CNT_LO_W + low part.
- R5: If the combined edge count wraps past its all-ones value, `overflow` is set for that measurement. `result` then holds the wrapped count.
- R6: With `mode_recip`=1 at the start strobe, the first rising edge arms the measurement. The second rising edge ends it, and `result` equals the number of reference cycles between the two edge detections. For a steady signal this is its period in cycles.
- R7: In interval mode, if no completing edge has arrived TIMEOUT cycles after the start cycle, `overflow` goes to 1, `result` goes to 0 and `result_valid` pulses.
- R8: A start strobe aborts any measurement in progress. In the next cycle it clears `result` to 0 and clears `result_valid` and `overflow`.
- R9: `result_valid` is a single-cycle pulse. `result` and `overflow` hold their values until the next start strobe.
- R10: Changes to `gate_len` and `mode_recip` after the start strobe have no effect on the measurement in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| sig_in | input | 1 | Asynchronous signal under test |
| gate_len | input | GATE_W | Window length in reference cycles (0 acts as 1) |
| mode_recip | input | 1 | 0 = window mode, 1 = interval mode; sampled at `start` |
| start | input | 1 | Single-cycle strobe that begins a measurement |
| result | output | CNT_LO_W+CNT_HI_W | Edge count or period in cycles |
| result_valid | output | 1 | Pulses for one cycle when a measurement ends |
| overflow | output | 1 | Edge count wrapped, or interval timeout occurred |

## Verification
The signal is driven in several shapes, and each shape separates one kind of fault:
- A symmetric square wave whose period divides the window checks that the window length is exact.
- A square wave at the fastest rate, with a long window, checks the carry into the extension counter and the wrap into overflow.
- A narrow high pulse with a long low phase shows that only rising transitions count and that one-cycle pulses survive synchronization.
- In interval mode, symmetric and strongly asymmetric waves show that the result is the full period and not one phase.
- A signal held at a constant level exercises the timeout path, including a zero-length window.

A behavioural model in the bench tracks every cycle, including aborted runs and inputs changed in mid-measurement.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_ARM  = 2'd2,
    ST_MEAS = 2'd3
  } fm_state_e;

  // Index of the final window cycle; a zero length behaves as one cycle.
  function automatic logic [31:0] fm_last_tick(input logic [31:0] len);
    return (len == 32'd0) ? 32'd0 : len - 32'd1;
  endfunction

  // Interval timeout reached when the elapsed counter hits limit-1 or more.
  function automatic logic fm_timeout_hit(input logic [31:0] elapsed,
                                          input logic [31:0] limit);
    return elapsed >= (limit - 32'd1);
  endfunction

endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

  // R2: a detected rise lasts exactly one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/fm_window_timer.sv
module fm_window_timer
  import fm_pkg::*;
#(
  parameter int GATE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [GATE_W-1:0] len,
  output logic              expire
);
  logic [GATE_W-1:0] tick;
  logic [GATE_W-1:0] last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      last <= '0;
    end else if (load) begin
      tick <= '0;
      last <= GATE_W'(fm_last_tick(32'(len)));
    end else if (run) begin
      tick <= tick + GATE_W'(1);
    end
  end

  assign expire = run && (tick == last);

  // R3: the timer never runs beyond its programmed window
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> tick <= last);

endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
  parameter int LO_W = 16,
  parameter int HI_W = 16,
  localparam int TOT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [TOT_W-1:0] total_next,
  output logic             rollover,
  output logic             wrap
);
  logic [LO_W-1:0] lo;
  logic [HI_W-1:0] hi;
  logic [LO_W-1:0] lo_n;
  logic [HI_W-1:0] hi_n;

  assign rollover   = inc && (&lo);
  assign wrap       = rollover && (&hi);
  assign lo_n       = lo + {{(LO_W-1){1'b0}}, inc};
  assign hi_n       = hi + {{(HI_W-1){1'b0}}, rollover};
  assign total_next = {hi_n, lo_n};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  // R4: every low-part rollover carries into the extension
  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    rollover && !clear |=> lo == '0 && hi == $past(hi) + HI_W'(1));

endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int GATE_W   = 24,
  parameter int CNT_LO_W = 16,
  parameter int CNT_HI_W = 16,
  parameter int TIMEOUT  = 1000000,
  localparam int RES_W   = CNT_LO_W + CNT_HI_W,
  localparam int TMO_W   = $clog2(TIMEOUT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic [GATE_W-1:0] gate_len,
  input  logic              mode_recip,
  input  logic              start,
  output logic [RES_W-1:0]  result,
  output logic              result_valid,
  output logic              overflow
);
  fm_state_e        state;
  logic [RES_W-1:0] pcnt;
  logic [TMO_W-1:0] elapsed;

  // named internal events
  logic             sig_rise;
  logic             gate_run;
  logic             cnt_inc;
  logic             win_expire;
  logic [RES_W-1:0] cnt_total_next;
  logic             cnt_roll;
  logic             cnt_wrap;
  logic             recip_busy;
  logic             recip_arm;
  logic             recip_done;
  logic             tmo_hit;
  logic             recip_timeout;

  fm_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(sig_rise)
  );

  assign gate_run = (state == ST_GATE);
  assign cnt_inc  = gate_run && sig_rise;

  fm_window_timer #(.GATE_W(GATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .run(gate_run && !start),
    .len(gate_len), .expire(win_expire)
  );

  fm_edge_counter #(.LO_W(CNT_LO_W), .HI_W(CNT_HI_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(start), .inc(cnt_inc),
    .total_next(cnt_total_next), .rollover(cnt_roll), .wrap(cnt_wrap)
  );

  assign recip_busy    = (state == ST_ARM) || (state == ST_MEAS);
  assign recip_arm     = (state == ST_ARM) && sig_rise;
  assign recip_done    = (state == ST_MEAS) && sig_rise;
  assign tmo_hit       = fm_timeout_hit(32'(elapsed), 32'(TIMEOUT));
  assign recip_timeout = recip_busy && !sig_rise && tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      result       <= '0;
      result_valid <= 1'b0;
      overflow     <= 1'b0;
      pcnt         <= '0;
      elapsed      <= '0;
    end else begin
      result_valid <= 1'b0;
      if (start) begin
        state    <= mode_recip ? ST_ARM : ST_GATE;
        result   <= '0;
        overflow <= 1'b0;
        pcnt     <= '0;
        elapsed  <= '0;
      end else begin
        case (state)
          ST_GATE: begin
            if (cnt_wrap) overflow <= 1'b1;
            if (win_expire) begin
              result       <= cnt_total_next;
              result_valid <= 1'b1;
              state        <= ST_IDLE;
            end
          end
          ST_ARM: begin
            elapsed <= elapsed + TMO_W'(1);
            if (recip_arm) begin
              pcnt  <= RES_W'(1);
              state <= ST_MEAS;
            end else if (recip_timeout) begin
              overflow     <= 1'b1;
              result       <= '0;
              result_valid <= 1'b1;
              state        <= ST_IDLE;
            end
          end
          ST_MEAS: begin
            elapsed <= elapsed + TMO_W'(1);
            if (recip_done) begin
              result       <= pcnt;
              result_valid <= 1'b1;
              state        <= ST_IDLE;
            end else if (recip_timeout) begin
              overflow     <= 1'b1;
              result       <= '0;
              result_valid <= 1'b1;
              state        <= ST_IDLE;
            end else begin
              pcnt <= pcnt + RES_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Assertion support: an independent window-length tracker.
  logic [31:0] chk_since;
  logic [31:0] chk_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_since <= '0;
      chk_len   <= 32'd1;
    end else if (start) begin
      chk_since <= '0;
      chk_len   <= (gate_len == '0) ? 32'd1 : 32'(gate_len);
    end else if (gate_run) begin
      chk_since <= chk_since + 32'd1;
    end
  end

  // R3: the window closes after exactly the latched number of cycles
  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire && !start |-> chk_since + 32'd1 == chk_len);

  // R5: an edge-count wrap raises overflow
  a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap && !start |=> overflow);

  // R6: a completed period is nonzero and bounded by the timeout
  a_r6_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
    recip_done |-> pcnt != '0 && 32'(pcnt) <= 32'(TIMEOUT));

  // R7: a timeout reports overflow with a zero result
  a_r7_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    recip_timeout && !start |=> result_valid && overflow && result == '0);

  // R8: a start strobe clears the outputs
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !result_valid && !overflow && result == '0);

  // R9: valid is a single-cycle pulse
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid && !start |=> !result_valid);

  // R9: results hold while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start && state == ST_IDLE |=> $stable(result) && $stable(overflow));

endmodule

// File: tb/test_freq_meter.sv
module test_freq_meter;
  localparam int GW  = 16;
  localparam int LO  = 8;
  localparam int HI  = 4;
  localparam int TMO = 3000;
  localparam int RW  = LO + HI;
  localparam int WRAP = 1 << RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_in = 1'b0;
  logic [GW-1:0] gate_len = '0;
  logic          mode_recip = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] result;
  logic          result_valid;
  logic          overflow;

  freq_meter #(.GATE_W(GW), .CNT_LO_W(LO), .CNT_HI_W(HI), .TIMEOUT(TMO)) i_freq_meter (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .gate_len(gate_len),
    .mode_recip(mode_recip), .start(start), .result(result),
    .result_valid(result_valid), .overflow(overflow)
  );

  always #4 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // signal generator controls
  bit sig_en = 0;
  bit sig_lvl = 0;
  int sig_hi = 1;
  int sig_lo = 1;

  // reference model state
  int m_state = 0; // 0 idle, 1 window, 2 arm, 3 measure
  int p1 = 0, p2 = 0, p3 = 0;
  int m_cnt = 0, m_el = 0, m_len = 1, m_per = 0, m_res = 0;
  bit m_val = 0, m_ovf = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; p3 = 0;
      m_state = 0; m_res = 0; m_val = 0; m_ovf = 0;
    end else begin
      bit e;
      e = (p2 == 1) && (p3 == 0);
      p3 = p2; p2 = p1; p1 = int'(sig_in);
      m_val = 0;
      if (start) begin
        m_state = mode_recip ? 2 : 1;
        m_len = (gate_len == 0) ? 1 : int'(gate_len);
        m_cnt = 0; m_el = 0; m_res = 0; m_ovf = 0;
      end else if (m_state == 1) begin
        m_el++;
        if (e) begin
          m_cnt++;
          if (m_cnt == WRAP) begin m_cnt = 0; m_ovf = 1; end
        end
        if (m_el == m_len) begin m_res = m_cnt; m_val = 1; m_state = 0; end
      end else if (m_state == 2) begin
        m_el++;
        if (e) begin m_state = 3; m_per = 1; end
        else if (m_el >= TMO) begin m_ovf = 1; m_res = 0; m_val = 1; m_state = 0; end
      end else if (m_state == 3) begin
        m_el++;
        if (e) begin m_res = m_per; m_val = 1; m_state = 0; end
        else if (m_el >= TMO) begin m_ovf = 1; m_res = 0; m_val = 1; m_state = 0; end
        else m_per++;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (int'(result) != m_res || result_valid != m_val || overflow != m_ovf) begin
        bad++;
        $display("FAIL %s model: result=%0d valid=%0b ovf=%0b expected result=%0d valid=%0b ovf=%0b",
                 cur_req, result, result_valid, overflow, m_res, m_val, m_ovf);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check_eq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(bit m, int len);
    @(negedge clk);
    start = 1'b1; mode_recip = m; gate_len = GW'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(string req, int max_cyc);
    bit seen = 0;
    for (int i = 0; i < max_cyc && !seen; i++) begin
      @(negedge clk);
      if (result_valid) seen = 1;
    end
    if (!seen) begin
      total++; bad++;
      $display("FAIL %s: actual=no valid expected=valid within %0d cycles", req, max_cyc);
    end
  endtask

  task automatic set_wave(int hi, int lo);
    sig_hi = hi; sig_lo = lo; sig_en = 1;
    repeat (2 * (hi + lo) + 4) @(negedge clk);
  endtask

  // signal generator
  initial begin
    forever begin
      if (!sig_en) begin
        sig_in = sig_lvl;
        @(negedge clk);
      end else begin
        sig_in = 1'b1;
        repeat (sig_hi) @(negedge clk);
        sig_in = 1'b0;
        repeat (sig_lo) @(negedge clk);
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    cur_req = "R1";
    check_eq("R1 result", int'(result), 0);
    check_eq("R1 valid", int'(result_valid), 0);
    check_eq("R1 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: window count with a period dividing the window
    cur_req = "R3";
    set_wave(5, 5);
    pulse_start(0, 200);
    wait_valid("R3", 400);
    check_eq("R3 window count", int'(result), 20);

    // R3: zero length acts as one cycle
    sig_en = 0; sig_lvl = 1;
    repeat (6) @(negedge clk);
    pulse_start(0, 0);
    check_eq("R3 zero-len early valid", int'(result_valid), 0);
    @(negedge clk);
    check_eq("R3 zero-len valid", int'(result_valid), 1);
    check_eq("R3 zero-len count", int'(result), 0);

    // R10: inputs changed mid-run are ignored
    cur_req = "R10";
    set_wave(5, 5);
    pulse_start(0, 300);
    repeat (20) @(negedge clk);
    gate_len = GW'(3); mode_recip = 1'b1;
    wait_valid("R10", 600);
    check_eq("R10 count", int'(result), 30);

    // R2: narrow high pulses, rising edges only
    cur_req = "R2";
    set_wave(1, 9);
    pulse_start(0, 200);
    wait_valid("R2", 400);
    check_eq("R2 narrow pulses", int'(result), 20);

    // R4: carry into the extension
    cur_req = "R4";
    set_wave(1, 1);
    pulse_start(0, 600);
    wait_valid("R4", 800);
    check_eq("R4 extended count", int'(result), 300);
    check_eq("R4 no overflow", int'(overflow), 0);

    // R5: full wrap
    cur_req = "R5";
    pulse_start(0, 9000);
    wait_valid("R5", 9200);
    check_eq("R5 wrapped count", int'(result), 4500 - WRAP);
    check_eq("R5 overflow", int'(overflow), 1);

    // R6: interval mode, symmetric and asymmetric
    cur_req = "R6";
    set_wave(20, 20);
    pulse_start(1, 0);
    wait_valid("R6", 200);
    check_eq("R6 symmetric period", int'(result), 40);
    check_eq("R6 no overflow", int'(overflow), 0);
    set_wave(3, 50);
    pulse_start(1, 0);
    wait_valid("R6", 300);
    check_eq("R6 asymmetric period", int'(result), 53);

    // R7: quiet input times out
    cur_req = "R7";
    sig_en = 0; sig_lvl = 0;
    repeat (6) @(negedge clk);
    pulse_start(1, 0);
    wait_valid("R7", TMO + 50);
    check_eq("R7 overflow", int'(overflow), 1);
    check_eq("R7 zero result", int'(result), 0);

    // R8: start clears and aborts
    cur_req = "R8";
    set_wave(5, 5);
    pulse_start(0, 500);
    check_eq("R8 overflow cleared", int'(overflow), 0);
    check_eq("R8 result cleared", int'(result), 0);
    repeat (100) @(negedge clk);
    pulse_start(0, 100);
    wait_valid("R8", 300);
    check_eq("R8 restarted count", int'(result), 10);

    // R9: pulse width and hold
    cur_req = "R9";
    @(negedge clk);
    check_eq("R9 valid pulse", int'(result_valid), 0);
    repeat (40) @(negedge clk);
    check_eq("R9 result held", int'(result), 10);
    check_eq("R9 valid low", int'(result_valid), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule